// File: doc/BRIEF.md
# Geodesic Reconstruction Stage

This block is one step of an iterative grey-level reconstruction. It receives two pixel streams of the same raster image side by side: the current marker and the mask. For every pixel it produces the next marker, the 3×3 flat dilation of the marker clipped from above by the mask (pixel-wise minimum). A configuration bit selects the dual step, a 3×3 erosion clipped from below by the mask (pixel-wise maximum). The mask and the frame-start and line-end flags leave the stage aligned with the new marker. An identical stage can therefore be connected directly to the output, so a chain of stages performs several iterations in one pass.

The 3×3 window is split into two parts. A horizontal 3-tap run uses two pixel registers. A vertical 3-tap run uses two circular line buffers whose length follows the programmed image width. The mask rides in the first line buffer next to the horizontal result, so it arrives delayed by exactly one line plus one pixel, the same delay as the dilated marker. Neighbours outside the image are replaced by 0 for dilation and by the all-ones value for erosion. After the final pixel of a frame the stage pushes out the last line plus one pixel by itself, and it refuses input while it does so.

Both streams use valid/ready. An input pair transfers on a clock edge where `in_valid` and `in_ready` are both high. An output transfers where `out_valid` and `out_ready` are both high. While an output is held, the whole stage freezes: `in_ready` drops and every internal register keeps its value, so marker and mask cannot slip apart. `out_valid` never waits on `out_ready`, and the output holds its value until it is taken. The configuration pins must stay stable while a frame is in flight. The width must be 2 to `MAX_WIDTH` and the height 2 to `MAX_HEIGHT`.

Top module: `geo_recon_stage`

## Requirements
- R1: With `cfg_erode` = 0, each output marker equals min(mask at the pixel, max of the marker over the 3×3 window centred on the pixel), with window positions outside the image counting as 0.
- R2: With `cfg_erode` = 1, each output marker equals max(mask at the pixel, min of the marker over the 3×3 window), with window positions outside the image counting as 255 (all ones).
- R3: The window edges follow the programmed `cfg_width` N and `cfg_height` H. Results are exact for N = 2 and for N = `MAX_WIDTH`.
- R4: Output pixel j carries the mask of input pixel j unchanged. `out_sof` is high for j = 0, and `out_eol` is high at column N-1, as they were given on input.
- R5: Exactly one output is produced per accepted pixel, in raster order. With no stalls, output 0 is first valid right after pixel N+1 is accepted (lag of one line plus one pixel). After the last pixel of a frame the stage flushes the remaining N+1 outputs by itself, and `in_ready` stays low until the last output has been emitted.
- R6: While `out_valid` is high and `out_ready` is low, all output fields hold their values and `in_ready` is low.
- R7: During and right after reset `out_valid` is 0 and `in_ready` is 1. A reset in the middle of a frame discards it, and the next frame is processed correctly.
- R8: Frames follow one another with no effect of the previous frame on the next. This holds even when the width changes between frames.
- R9: With `in_valid` and `out_ready` held high, a frame of N×H pixels completes its last output N×H+N+1 cycles after its first pixel is accepted (one pixel per cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | CW = clog2(MAX_WIDTH+1) | Image width N in pixels |
| cfg_height | input | RW = clog2(MAX_HEIGHT+1) | Image height H in lines |
| cfg_erode | input | 1 | 0: dilate and clip by mask (min); 1: erode and clip by mask (max) |
| in_valid | input | 1 | Input pixel pair present |
| in_ready | output | 1 | Stage accepts the input pair this cycle |
| in_marker | input | PIX_W | Current marker pixel |
| in_mask | input | PIX_W | Mask pixel |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| out_valid | output | 1 | Output pixel pair present |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_marker | output | PIX_W | Next marker pixel |
| out_mask | output | PIX_W | Mask pixel aligned with the output marker |
| out_sof | output | 1 | Frame-start flag aligned with the output |
| out_eol | output | 1 | Line-end flag aligned with the output |

## Verification
The bench goes after the four image borders with single bright or dark spots placed at corners and at the last column. A design that wraps the horizontal window across lines, or leaks a row from below the frame, reports a neighbour's value there. Widths of 2 and of the maximum exercise the line-buffer wrap; an off-by-one pointer shifts every vertical neighbour by a column. Stalls on both sides and a still-valid input offered during the end-of-frame flush expose a design that lets marker and mask drift apart, accepts pixels while flushing, or drops the final line. Back-to-back frames with a width change and a reset in mid-frame show whether stale line-buffer contents reach the top row of the next image.

// File: rtl/geo_pkg.sv
package geo_pkg;

  // Which of the two stream operations a stage applies.
  typedef enum logic {
    GEO_DILATE = 1'b0,
    GEO_ERODE  = 1'b1
  } geo_mode_e;

  // Selection rule of a two-input rank cell: dilation keeps the larger
  // operand, erosion keeps the smaller one.
  function automatic logic keep_first(input logic first_larger, input geo_mode_e mode);
    return (mode == GEO_ERODE) ? !first_larger : first_larger;
  endfunction

endpackage

// File: rtl/geo_line_buf.sv
// Circular one-line delay: the word read at an enabled cycle is the one
// written len enabled cycles earlier.
module geo_line_buf #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  parameter int LW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] len,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] ptr;
  logic          wrap;

  assign wrap    = (LW'(ptr) + LW'(1)) >= len;
  assign rd_data = mem[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (en) begin
      ptr <= wrap ? '0 : ptr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (en) mem[ptr] <= wr_data;
  end
endmodule

// File: rtl/geo_raster_ctl.sv
// Raster bookkeeping of the stage: input position, the column of the
// horizontal window centre, the output position, the fill lag and the
// end-of-frame flush.
module geo_raster_ctl #(
  parameter int MAX_WIDTH  = 64,
  parameter int MAX_HEIGHT = 1024,
  localparam int CW = $clog2(MAX_WIDTH + 1),
  localparam int RW = $clog2(MAX_HEIGHT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          take,
  input  logic [CW-1:0] cfg_width,
  input  logic [RW-1:0] cfg_height,
  output logic          col_first,
  output logic          col_last,
  output logic          row_top,
  output logic          row_bot,
  output logic          emit,
  output logic          flushing
);
  localparam int SW = $clog2(MAX_WIDTH + 2);

  logic [CW-1:0] in_col, ctr_col, out_col;
  logic [RW-1:0] in_row, out_row;
  logic [SW-1:0] seen;
  logic          in_col_end, in_row_end, out_col_end, out_row_end;
  logic          seen_full, out_last;

  assign in_col_end  = in_col  == (cfg_width  - CW'(1));
  assign in_row_end  = in_row  == (cfg_height - RW'(1));
  assign out_col_end = out_col == (cfg_width  - CW'(1));
  assign out_row_end = out_row == (cfg_height - RW'(1));
  assign seen_full   = seen == (SW'(cfg_width) + SW'(1));
  assign out_last    = out_col_end && out_row_end;

  assign emit      = adv && seen_full;
  assign col_first = ctr_col == '0;
  assign col_last  = ctr_col == (cfg_width - CW'(1));
  assign row_top   = out_row == '0;
  assign row_bot   = out_row_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_col   <= '0;
      in_row   <= '0;
      ctr_col  <= '0;
      out_col  <= '0;
      out_row  <= '0;
      seen     <= '0;
      flushing <= 1'b0;
    end else begin
      if (take) begin
        if (in_col_end) begin
          in_col <= '0;
          in_row <= in_row_end ? '0 : in_row + RW'(1);
        end else begin
          in_col <= in_col + CW'(1);
        end
      end

      if (adv) begin
        ctr_col <= take ? in_col : '0;
        if (emit && out_last) seen <= '0;
        else if (!seen_full)  seen <= seen + SW'(1);
      end

      if (emit) begin
        if (out_col_end) begin
          out_col <= '0;
          out_row <= out_row_end ? '0 : out_row + RW'(1);
        end else begin
          out_col <= out_col + CW'(1);
        end
      end

      if (take && in_col_end && in_row_end) flushing <= 1'b1;
      else if (emit && out_last)            flushing <= 1'b0;
    end
  end
endmodule

// File: rtl/geo_recon_stage.sv
module geo_recon_stage #(
  parameter int PIX_W      = 8,
  parameter int MAX_WIDTH  = 64,
  parameter int MAX_HEIGHT = 1024,
  localparam int CW = $clog2(MAX_WIDTH + 1),
  localparam int RW = $clog2(MAX_HEIGHT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_width,
  input  logic [RW-1:0]    cfg_height,
  input  logic             cfg_erode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_marker,
  input  logic [PIX_W-1:0] in_mask,
  input  logic             in_sof,
  input  logic             in_eol,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_marker,
  output logic [PIX_W-1:0] out_mask,
  output logic             out_sof,
  output logic             out_eol
);
  import geo_pkg::*;

  localparam int LB1_W = 2 * PIX_W + 2;

  geo_mode_e mode;
  assign mode = geo_mode_e'(cfg_erode);

  function automatic logic [PIX_W-1:0] rank2(input logic [PIX_W-1:0] p,
                                             input logic [PIX_W-1:0] q,
                                             input geo_mode_e m);
    return keep_first(p > q, m) ? p : q;
  endfunction

  logic             out_space, take, adv, emit, flushing;
  logic             col_first, col_last, row_top, row_bot;
  logic [PIX_W-1:0] pad, x_mk;
  logic [PIX_W-1:0] a_mk, b_mk, a_msk;
  logic             a_sof, a_eol;
  logic [PIX_W-1:0] h_new, v_mid, v_top, d_msk, v_res, nxt_mk;
  logic             d_sof, d_eol;
  logic [LB1_W-1:0] lb1_wr, lb1_rd;

  // Handshake: the whole stage advances as one; a held output freezes it.
  assign out_space = !out_valid || out_ready;
  assign in_ready  = !flushing && out_space;
  assign take      = in_valid && in_ready;
  assign adv       = out_space && (flushing || in_valid);

  assign pad  = {PIX_W{cfg_erode}};
  assign x_mk = take ? in_marker : pad;

  geo_raster_ctl #(
    .MAX_WIDTH (MAX_WIDTH),
    .MAX_HEIGHT(MAX_HEIGHT)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .take      (take),
    .cfg_width (cfg_width),
    .cfg_height(cfg_height),
    .col_first (col_first),
    .col_last  (col_last),
    .row_top   (row_top),
    .row_bot   (row_bot),
    .emit      (emit),
    .flushing  (flushing)
  );

  // Horizontal run: window centre is the previous slot (register a).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_mk  <= '0;
      b_mk  <= '0;
      a_msk <= '0;
      a_sof <= 1'b0;
      a_eol <= 1'b0;
    end else if (adv) begin
      b_mk  <= a_mk;
      a_mk  <= x_mk;
      a_msk <= take ? in_mask : '0;
      a_sof <= take && in_sof;
      a_eol <= take && in_eol;
    end
  end

  assign h_new = rank2(rank2(col_first ? pad : b_mk, a_mk, mode),
                       col_last ? pad : x_mk, mode);

  // Vertical run: first buffer also carries mask and flags of the same
  // pixel so they come out with the same one-line-plus-one delay.
  assign lb1_wr = {h_new, a_msk, a_sof, a_eol};

  geo_line_buf #(
    .W    (LB1_W),
    .DEPTH(MAX_WIDTH),
    .LW   (CW)
  ) u_lb_near (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (adv),
    .len    (cfg_width),
    .wr_data(lb1_wr),
    .rd_data(lb1_rd)
  );

  assign {v_mid, d_msk, d_sof, d_eol} = lb1_rd;

  geo_line_buf #(
    .W    (PIX_W),
    .DEPTH(MAX_WIDTH),
    .LW   (CW)
  ) u_lb_far (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (adv),
    .len    (cfg_width),
    .wr_data(v_mid),
    .rd_data(v_top)
  );

  assign v_res  = rank2(rank2(row_top ? pad : v_top, v_mid, mode),
                        row_bot ? pad : h_new, mode);
  // Clip against the mask with the opposite rank of the window.
  assign nxt_mk = rank2(d_msk, v_res, (mode == GEO_ERODE) ? GEO_DILATE : GEO_ERODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_marker <= '0;
      out_mask   <= '0;
      out_sof    <= 1'b0;
      out_eol    <= 1'b0;
    end else if (adv) begin
      out_valid <= emit;
      if (emit) begin
        out_marker <= nxt_mk;
        out_mask   <= d_msk;
        out_sof    <= d_sof;
        out_eol    <= d_eol;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/geo_recon_stage_chk.sv
module geo_recon_stage_chk #(
  parameter int PIX_W = 8,
  parameter int CW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    cfg_width,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_marker,
  input logic [PIX_W-1:0] out_mask,
  input logic             out_sof,
  input logic             out_eol
);
  logic [31:0] acc_cnt, del_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      del_cnt <= '0;
    end else begin
      if (in_valid && in_ready)   acc_cnt <= acc_cnt + 32'd1;
      if (out_valid && out_ready) del_cnt <= del_cnt + 32'd1;
    end
  end

  // R6: a refused output keeps every field.
  assert_hold_output_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_marker) &&
      $stable(out_mask) && $stable(out_sof) && $stable(out_eol)));

  // R6: back-pressure reaches the input in the same cycle.
  assert_stall_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R5: never more outputs than accepted pixels.
  assert_no_excess_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (acc_cnt > del_cnt));

  // R5: in-flight pixels bounded by one line plus the pipeline registers.
  assert_bounded_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_cnt - del_cnt) <= (32'(cfg_width) + 32'd2));

  // R7: leaving reset, nothing is presented and input is open.
  assert_reset_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));
endmodule

bind geo_recon_stage geo_recon_stage_chk #(.PIX_W(PIX_W), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_width (cfg_width),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_marker(out_marker),
  .out_mask  (out_mask),
  .out_sof   (out_sof),
  .out_eol   (out_eol)
);

// File: tb/geo_recon_stage_test.sv
`timescale 1ns/1ps
module geo_recon_stage_test;
  localparam int PIX_W      = 8;
  localparam int MAX_WIDTH  = 64;
  localparam int MAX_HEIGHT = 1024;
  localparam int CW         = $clog2(MAX_WIDTH + 1);
  localparam int RW         = $clog2(MAX_HEIGHT + 1);
  localparam int MAXPIX     = 384;
  localparam int NCASE      = 7;

  // {width[8], height[8], erode[1], pattern[3], stall[4], seed[8]}
  localparam logic [31:0] CASES [NCASE] = '{
    {8'd8,  8'd5, 1'b0, 3'd0, 4'd0, 8'd1},
    {8'd8,  8'd5, 1'b1, 3'd0, 4'd0, 8'd2},
    {8'd2,  8'd3, 1'b0, 3'd0, 4'd1, 8'd3},
    {8'd64, 8'd3, 1'b0, 3'd2, 4'd0, 8'd4},
    {8'd7,  8'd4, 1'b0, 3'd1, 4'd2, 8'd5},
    {8'd5,  8'd6, 1'b1, 3'd1, 4'd2, 8'd6},
    {8'd6,  8'd2, 1'b0, 3'd0, 4'd3, 8'd7}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CW-1:0]    cfg_width = CW'(8);
  logic [RW-1:0]    cfg_height = RW'(5);
  logic             cfg_erode = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [PIX_W-1:0] in_marker = '0;
  logic [PIX_W-1:0] in_mask = '0;
  logic             in_sof = 1'b0;
  logic             in_eol = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [PIX_W-1:0] out_marker;
  logic [PIX_W-1:0] out_mask;
  logic             out_sof;
  logic             out_eol;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] img_mk  [MAXPIX];
  logic [7:0] img_msk [MAXPIX];
  logic [7:0] exp_mk  [MAXPIX];

  always #4 clk = ~clk;

  geo_recon_stage #(
    .PIX_W(PIX_W), .MAX_WIDTH(MAX_WIDTH), .MAX_HEIGHT(MAX_HEIGHT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_erode(cfg_erode), .in_valid(in_valid), .in_ready(in_ready),
    .in_marker(in_marker), .in_mask(in_mask), .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_marker(out_marker),
    .out_mask(out_mask), .out_sof(out_sof), .out_eol(out_eol)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  function automatic logic [7:0] mix(input int v);
    int t;
    t = v * 73 + 19;
    t = t ^ (t >> 3);
    return 8'((t * 29) >> 2);
  endfunction

  task automatic build(input int n, input int h, input bit erode,
                       input int pat, input int seed);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < n; c++) begin
        int i;
        i = r * n + c;
        case (pat)
          1: begin
            if (!erode) begin
              img_msk[i] = (r == 0 && c == n - 2) ? 8'd100 : 8'd200;
              img_mk[i]  = ((r == 1 && c == n - 1) || (r == h - 1 && c == 0)) ? 8'd150 : 8'd0;
            end else begin
              img_msk[i] = 8'd40;
              img_mk[i]  = ((r == h - 1 && c == 0) || (r == 0 && c == n - 1)) ? 8'd60 : 8'd255;
            end
          end
          2: begin
            img_msk[i] = 8'(255 - c * 3);
            img_mk[i]  = 8'(c * 4 + r * 9);
          end
          default: begin
            img_msk[i] = mix(i + seed * 101);
            img_mk[i]  = mix(i * 7 + seed + 5);
          end
        endcase
      end
    end
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < n; c++) begin
        logic [7:0] acc, msk;
        acc = erode ? 8'd255 : 8'd0;
        for (int dr = -1; dr <= 1; dr++) begin
          for (int dc = -1; dc <= 1; dc++) begin
            int rr, cc;
            rr = r + dr;
            cc = c + dc;
            if (rr >= 0 && rr < h && cc >= 0 && cc < n) begin
              logic [7:0] v;
              v = img_mk[rr * n + cc];
              if (erode) acc = (v < acc) ? v : acc;
              else       acc = (v > acc) ? v : acc;
            end
          end
        end
        msk = img_msk[r * n + c];
        exp_mk[r * n + c] = erode ? ((msk > acc) ? msk : acc) : ((msk < acc) ? msk : acc);
      end
    end
  endtask

  function automatic bit vld_pat(input int stall, input int cyc);
    case (stall)
      1: return (cyc % 3) != 0;
      2: return ((cyc * 7) % 5) < 3;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit rdy_pat(input int stall, input int cyc);
    case (stall)
      2: return ((cyc * 3) % 7) < 4;
      3: return (cyc % 4) != 0;
      default: return 1'b1;
    endcase
  endfunction

  // Drives one frame, checks every output; returns case and row-0 mismatches.
  task automatic run_frame(input int n, input int h, input bit erode, input int pat,
                           input int seed, input int stall,
                           output int bad_case, output int bad_row0);
    int iidx, oidx, cyc, extra_acc;
    bit hold_pend;
    logic [7:0] h_mk, h_msk;
    logic [1:0] h_fl;
    string mreq;
    build(n, h, erode, pat, seed);
    mreq = erode ? "R2" : "R1";
    @(negedge clk);
    cfg_width  = CW'(n);
    cfg_height = RW'(h);
    cfg_erode  = erode;
    iidx = 0; oidx = 0; cyc = 0; extra_acc = 0;
    bad_case = 0; bad_row0 = 0; hold_pend = 1'b0;
    h_mk = '0; h_msk = '0; h_fl = '0;
    while (oidx < n * h && cyc < 6000) begin
      @(negedge clk);
      cyc++;
      out_ready = rdy_pat(stall, cyc);
      if (iidx < n * h) begin
        in_valid  = vld_pat(stall, cyc);
        in_marker = img_mk[iidx];
        in_mask   = img_msk[iidx];
        in_sof    = (iidx == 0);
        in_eol    = (iidx % n) == n - 1;
      end else begin
        in_valid  = (oidx < n * h - 1);
        in_marker = 8'hA5;
        in_mask   = 8'h5A;
        in_sof    = 1'b1;
        in_eol    = 1'b0;
      end
      #1;
      if (hold_pend) begin
        check(out_valid && out_marker == h_mk && out_mask == h_msk &&
              {out_sof, out_eol} == h_fl, "R6", "held output changed",
              int'(out_marker), int'(h_mk));
      end
      hold_pend = out_valid && !out_ready;
      h_mk = out_marker; h_msk = out_mask; h_fl = {out_sof, out_eol};
      if (out_valid && out_ready) begin
        bit ok;
        if (oidx == 0 && stall == 0)
          check(iidx == n + 2, "R5", "pixels accepted at first output", iidx, n + 2);
        ok = out_marker == exp_mk[oidx];
        check(ok, mreq, $sformatf("marker px %0d", oidx), int'(out_marker), int'(exp_mk[oidx]));
        check(out_mask == img_msk[oidx], "R4", $sformatf("mask px %0d", oidx),
              int'(out_mask), int'(img_msk[oidx]));
        check({out_sof, out_eol} == {oidx == 0, (oidx % n) == n - 1}, "R4",
              $sformatf("flags px %0d", oidx), int'({out_sof, out_eol}),
              int'({oidx == 0, (oidx % n) == n - 1}));
        if (!ok) begin
          bad_case++;
          if (oidx < n) bad_row0++;
        end
        oidx++;
      end
      if (in_valid && in_ready) begin
        if (iidx < n * h) iidx++;
        else extra_acc++;
      end
    end
    check(oidx == n * h, "R5", "outputs in frame", oidx, n * h);
    check(extra_acc == 0, "R5", "pixels accepted during flush", extra_acc, 0);
    if (stall == 0)
      check(cyc == n * h + n + 2, "R9", "cycles for unstalled frame", cyc, n * h + n + 2);
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin
    int bc, br;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R7", "idle after reset",
          int'({out_valid, in_ready}), 1);

    for (int ci = 0; ci < NCASE; ci++) begin
      logic [31:0] e;
      int n, h;
      e = CASES[ci];
      n = int'(e[31:24]);
      h = int'(e[23:16]);
      run_frame(n, h, e[15], int'(e[14:12]), int'(e[7:0]), int'(e[11:8]), bc, br);
      if (n == 2 || n == MAX_WIDTH)
        check(bc == 0, "R3", $sformatf("mismatches at width %0d", n), bc, 0);
      if (ci > 0)
        check(br == 0, "R8", $sformatf("top-row mismatches after frame %0d", ci - 1), br, 0);
    end

    // Directed: reset in the middle of a frame, then a clean frame.
    build(8, 5, 1'b0, 0, 9);
    @(negedge clk);
    cfg_width = CW'(8); cfg_height = RW'(5); cfg_erode = 1'b0;
    for (int k = 0; k < 13; k++) begin
      in_valid  = 1'b1;
      in_marker = img_mk[k];
      in_mask   = img_msk[k];
      in_sof    = (k == 0);
      in_eol    = (k % 8) == 7;
      @(negedge clk);
    end
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid under mid-frame reset", int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R7", "idle after mid-frame reset",
          int'({out_valid, in_ready}), 1);
    run_frame(8, 5, 1'b0, 0, 9, 0, bc, br);
    check(bc == 0, "R7", "frame after mid-frame reset", bc, 0);

    // Directed: dual mode with stalls at the corners after a width change.
    run_frame(3, 3, 1'b1, 1, 0, 2, bc, br);
    check(br == 0, "R8", "top row after width change", br, 0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule